// File: doc/BRIEF.md
# DDR3 Timing Parameter Converter

This block converts DDR3 speed-bin timing parameters into clock-cycle counts for a memory controller at a given clock frequency. Software or a boot sequencer supplies the clock frequency in MHz, thirteen timing durations (each with an optional minimum cycle count), and a small speed-bin table. Each table entry gives a CAS latency, a CAS write latency, and the clock-period window in which the entry applies. A one-cycle start pulse launches a conversion. The block first computes the clock period and selects the speed bin. It then converts each timing in a fixed order on one shared iterative divider, and finally publishes all results together with a one-cycle done pulse.

The results are the full-rate cycle counts and their half-rate register values. For a controller that runs at half the memory clock, each half-rate value is (n+1)/2. The block also publishes the turnaround and self-refresh values derived from the counts, and the scaled refresh fields. If the clock period falls in no table window, the block raises a one-cycle error pulse and leaves every output unchanged.

Top module: `ddr3_tmg_conv`

## Requirements
- R1: While reset is held and after it is released, every data output is zero and `done_o` and `err_o` are low until the first conversion finishes.
- R2: The clock period is tCK = floor(1,000,000 / MHz) in ps. The speed bin is the lowest-indexed table entry with tCKmin <= tCK < tCKmax, and it supplies `cl_o` and `cwl_o`.
- R3: When no table entry matches, `err_o` pulses high for one cycle 35 cycles after the clock edge that samples start. `done_o` stays low and every data output keeps its previous value.
- R4: Timing indices 1 (refresh cycle time, ns) and 3..12 (ps) convert as ceil(dur × MHz / D). D is 1000 for ns and 1,000,000 for ps. The index order is 0 refresh interval, 1 refresh cycle, 2 write recovery, 3 RAS-to-CAS, 4 precharge, 5 row cycle, 6 row active, 7 read-to-precharge, 8 write-to-read, 9 mode-register set, 10 row-to-row, 11 power-down exit, 12 CKE pulse.
- R5: Index 0 (refresh interval, ns) and index 2 (write recovery, ns) use floor(dur × MHz / 1000) instead of ceiling.
- R6: Each reported count is max(minimum cycle count, converted value), and a converted value above 65535 saturates to 65535.
- R7: The derived values are computed as follows:
  - CKE self-refresh = count[12] + 1
  - maximum row-active time = 9 × count[0]
  - write-to-read turnaround = 4 + CWL + count[8]
  - read-to-write turnaround = CL + 6 − CWL, modulo 2^16
- R8: Each value in `half_o` is (n+1)/2 of its full-rate value. Slots 0..12 hold the timings, slot 13 the CKE self-refresh value, slot 14 the write-to-read value and slot 15 the read-to-write value. `cl_half_o` and `cwl_half_o` halve CL and CWL the same way. `refi_x32_o` = count[0]/32 and `rasmax_x1024_o` = max row-active/1024, both rounded down.
- R9: `done_o` pulses high for exactly one cycle 478 cycles after the clock edge that samples start. All outputs change on that same edge and hold their values at every other time.
- R10: A start pulse that arrives while a conversion is running is ignored. That run produces a single done pulse, and its results come from the frequency sampled at the accepted start.
- R11: `done_o` and `err_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launch a conversion (ignored while busy) |
| freq_mhz_i | input | 12 | Memory clock frequency in MHz, sampled at start |
| dur_i | input | 260 | 13 durations of 20 bits, slot k at bits k*20 |
| ckmin_i | input | 208 | 13 minimum cycle counts of 16 bits |
| bin_cl_i | input | 25 | 5 CL values of 5 bits |
| bin_cwl_i | input | 25 | 5 CWL values of 5 bits |
| bin_tckmin_i | input | 80 | 5 lower tCK bounds in ps, inclusive |
| bin_tckmax_i | input | 80 | 5 upper tCK bounds in ps, exclusive |
| cyc_o | output | 208 | 13 full-rate cycle counts |
| half_o | output | 256 | 16 half-rate values |
| cl_o | output | 5 | Selected CAS latency |
| cwl_o | output | 5 | Selected CAS write latency |
| cl_half_o | output | 5 | (CL+1)/2 |
| cwl_half_o | output | 5 | (CWL+1)/2 |
| ckesr_o | output | 16 | CKE self-refresh minimum |
| wr2rd_o | output | 16 | Write-to-read turnaround |
| rd2wr_o | output | 16 | Read-to-write turnaround |
| rasmax_o | output | 20 | Maximum row-active time |
| refi_x32_o | output | 11 | Refresh interval / 32 |
| rasmax_x1024_o | output | 10 | Maximum row-active / 1024 |
| done_o | output | 1 | One-cycle result-valid pulse |
| err_o | output | 1 | One-cycle no-matching-bin pulse |

## Verification
Any fault in the divider or the sequencing index lands in a single timing slot or shifts the done cycle. The bench compares every output on every clock against a behavioural model, so such a fault shows at the exact edge where done rises. A wrong speed-bin choice shows at that edge as wrong CL/CWL, turnarounds and halved latencies. A busy state that restarts or stalls shows as a missing, early or doubled done pulse, or as an error pulse, within one conversion. The runs cover several frequencies, a tCK that two table entries accept, one that no entry accepts, a saturating duration, and a start pulse that arrives mid-run.

// File: rtl/ddr3_tmg_pkg.sv
package ddr3_tmg_pkg;

  localparam int N_TMG     = 13;
  localparam int BURST_LEN = 8;

  localparam int IX_REFI = 0;
  localparam int IX_RFC  = 1;
  localparam int IX_WR   = 2;
  localparam int IX_RCD  = 3;
  localparam int IX_RP   = 4;
  localparam int IX_RC   = 5;
  localparam int IX_RAS  = 6;
  localparam int IX_RTP  = 7;
  localparam int IX_WTR  = 8;
  localparam int IX_MOD  = 9;
  localparam int IX_RRD  = 10;
  localparam int IX_XP   = 11;
  localparam int IX_CKE  = 12;

  localparam logic [63:0] PS_PER_US_MHZ = 64'd1000000;
  localparam logic [63:0] NS_PER_US_MHZ = 64'd1000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TCK,
    ST_BIN,
    ST_CONV,
    ST_FIN
  } conv_state_e;

  // slots 0..2 are given in ns, the rest in ps
  function automatic logic unit_is_ns(int idx);
    return idx <= IX_WR;
  endfunction

  // refresh interval and write recovery truncate instead of rounding up
  function automatic logic rounds_down(int idx);
    return (idx == IX_REFI) || (idx == IX_WR);
  endfunction

  function automatic logic [63:0] unit_div(int idx);
    return unit_is_ns(idx) ? NS_PER_US_MHZ : PS_PER_US_MHZ;
  endfunction

  // dividend whose truncated quotient gives the wanted rounding
  function automatic logic [63:0] scaled_num(logic [63:0] dur, logic [63:0] mhz, int idx);
    logic [63:0] bias;
    bias = rounds_down(idx) ? 64'd0 : unit_div(idx) - 64'd1;
    return dur * mhz + bias;
  endfunction

endpackage

// File: rtl/ddr3_iter_div.sv
module ddr3_iter_div #(
  parameter int W = 33
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] quo,
  output logic         idle
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     rem_q, quo_q, den_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W:0]       rem_sh, rem_dif;
  logic             take;

  always_comb begin
    rem_sh  = {rem_q, quo_q[W-1]};
    rem_dif = rem_sh - {1'b0, den_q};
    take    = rem_sh >= {1'b0, den_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      rem_q <= '0;
      quo_q <= num;
      den_q <= den;
      cnt_q <= CNT_W'(W);
    end else if (cnt_q != '0) begin
      rem_q <= take ? rem_dif[W-1:0] : rem_sh[W-1:0];
      quo_q <= {quo_q[W-2:0], take};
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign quo  = quo_q;
  assign idle = (cnt_q == '0);

  // the last step must leave a remainder below the divisor
  p_rem_below_den_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(1) && !load) |=> (den_q == '0 || rem_q < den_q));

endmodule

// File: rtl/ddr3_bin_lookup.sv
module ddr3_bin_lookup #(
  parameter int N_BIN = 5,
  parameter int CL_W  = 5,
  parameter int TCK_W = 16,
  parameter int DIV_W = 33
) (
  input  logic [DIV_W-1:0]       tck,
  input  logic [N_BIN*CL_W-1:0]  bin_cl,
  input  logic [N_BIN*CL_W-1:0]  bin_cwl,
  input  logic [N_BIN*TCK_W-1:0] bin_tckmin,
  input  logic [N_BIN*TCK_W-1:0] bin_tckmax,
  output logic                   hit,
  output logic [CL_W-1:0]        cl,
  output logic [CL_W-1:0]        cwl
);
  logic [N_BIN-1:0] match;

  for (genvar b = 0; b < N_BIN; b++) begin : g_win
    assign match[b] = (DIV_W'(bin_tckmin[b*TCK_W +: TCK_W]) <= tck) &&
                      (tck < DIV_W'(bin_tckmax[b*TCK_W +: TCK_W]));
  end

  // scan downward so the lowest matching index wins
  always_comb begin
    cl  = '0;
    cwl = '0;
    for (int b = N_BIN - 1; b >= 0; b--) begin
      if (match[b]) begin
        cl  = bin_cl[b*CL_W +: CL_W];
        cwl = bin_cwl[b*CL_W +: CL_W];
      end
    end
    hit = |match;
  end

endmodule

// File: rtl/ddr3_half_fields.sv
module ddr3_half_fields #(
  parameter int M = 16,
  parameter int W = 16
) (
  input  logic [M*W-1:0] full,
  output logic [M*W-1:0] half
);
  for (genvar i = 0; i < M; i++) begin : g_half
    logic [W:0] inc;
    assign inc = {1'b0, full[i*W +: W]} + 1'b1;
    assign half[i*W +: W] = inc[W:1];
  end
endmodule

// File: rtl/ddr3_tmg_conv.sv
module ddr3_tmg_conv
  import ddr3_tmg_pkg::*;
#(
  parameter int DUR_W  = 20,
  parameter int FREQ_W = 12,
  parameter int CYC_W  = 16,
  parameter int CL_W   = 5,
  parameter int TCK_W  = 16,
  parameter int N_BIN  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [FREQ_W-1:0]        freq_mhz_i,
  input  logic [N_TMG*DUR_W-1:0]   dur_i,
  input  logic [N_TMG*CYC_W-1:0]   ckmin_i,
  input  logic [N_BIN*CL_W-1:0]    bin_cl_i,
  input  logic [N_BIN*CL_W-1:0]    bin_cwl_i,
  input  logic [N_BIN*TCK_W-1:0]   bin_tckmin_i,
  input  logic [N_BIN*TCK_W-1:0]   bin_tckmax_i,
  output logic [N_TMG*CYC_W-1:0]   cyc_o,
  output logic [(N_TMG+3)*CYC_W-1:0] half_o,
  output logic [CL_W-1:0]          cl_o,
  output logic [CL_W-1:0]          cwl_o,
  output logic [CL_W-1:0]          cl_half_o,
  output logic [CL_W-1:0]          cwl_half_o,
  output logic [CYC_W-1:0]         ckesr_o,
  output logic [CYC_W-1:0]         wr2rd_o,
  output logic [CYC_W-1:0]         rd2wr_o,
  output logic [CYC_W+3:0]         rasmax_o,
  output logic [CYC_W-6:0]         refi_x32_o,
  output logic [CYC_W-7:0]         rasmax_x1024_o,
  output logic                     done_o,
  output logic                     err_o
);
  localparam int DIV_W = DUR_W + FREQ_W + 1;
  localparam int RAS_W = CYC_W + 4;
  localparam int IDX_W = $clog2(N_TMG);
  localparam int M_HALF = N_TMG + 3;
  localparam logic [DIV_W-1:0] CYC_MAX = DIV_W'({CYC_W{1'b1}});

  conv_state_e         state_q;
  logic [IDX_W-1:0]    idx_q;
  logic [FREQ_W-1:0]   freq_q;
  logic [DIV_W-1:0]    tck_q;
  logic [CL_W-1:0]     cl_q, cwl_q;
  logic [CYC_W-1:0]    res_q [N_TMG];

  logic                div_load, div_idle;
  logic [DIV_W-1:0]    div_num, div_den, div_quo;
  logic                lu_hit;
  logic [CL_W-1:0]     lu_cl, lu_cwl;
  logic [CYC_W-1:0]    quo_sat, ck_floor, res_new;
  logic [CYC_W-1:0]    ckesr_w, wr2rd_w, rd2wr_w;
  logic [RAS_W-1:0]    rasmax_w;
  logic [N_TMG*CYC_W-1:0]  res_flat;
  logic [M_HALF*CYC_W-1:0] full_vec, half_vec;
  logic [CL_W:0]       cl_inc, cwl_inc;
  logic                last_idx;

  function automatic logic [DIV_W-1:0] num_for(int k);
    return DIV_W'(scaled_num(64'(dur_i[k*DUR_W +: DUR_W]), 64'(freq_q), k));
  endfunction

  function automatic logic [DIV_W-1:0] den_for(int k);
    return DIV_W'(unit_div(k));
  endfunction

  ddr3_iter_div #(.W(DIV_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .load (div_load),
    .num  (div_num),
    .den  (div_den),
    .quo  (div_quo),
    .idle (div_idle)
  );

  ddr3_bin_lookup #(.N_BIN(N_BIN), .CL_W(CL_W), .TCK_W(TCK_W), .DIV_W(DIV_W)) u_lu (
    .tck       (tck_q),
    .bin_cl    (bin_cl_i),
    .bin_cwl   (bin_cwl_i),
    .bin_tckmin(bin_tckmin_i),
    .bin_tckmax(bin_tckmax_i),
    .hit       (lu_hit),
    .cl        (lu_cl),
    .cwl       (lu_cwl)
  );

  // divider control: one load per conversion step
  assign last_idx = (idx_q == IDX_W'(N_TMG - 1));

  always_comb begin
    div_load = 1'b0;
    div_num  = DIV_W'(PS_PER_US_MHZ);
    div_den  = DIV_W'(freq_mhz_i);
    unique case (state_q)
      ST_IDLE: div_load = start_i;
      ST_BIN: begin
        div_load = lu_hit;
        div_num  = num_for(0);
        div_den  = den_for(0);
      end
      ST_CONV: begin
        div_load = div_idle && !last_idx;
        if (!last_idx) begin
          div_num = num_for(int'(idx_q) + 1);
          div_den = den_for(int'(idx_q) + 1);
        end
      end
      default: ;
    endcase
  end

  // saturate and apply the cycle floor
  always_comb begin
    quo_sat  = (div_quo > CYC_MAX) ? {CYC_W{1'b1}} : div_quo[CYC_W-1:0];
    ck_floor = ckmin_i[idx_q*CYC_W +: CYC_W];
    res_new  = (quo_sat > ck_floor) ? quo_sat : ck_floor;
  end

  // derived values from the finished counts
  always_comb begin
    ckesr_w  = res_q[IX_CKE] + 1'b1;
    wr2rd_w  = CYC_W'(BURST_LEN / 2) + CYC_W'(cwl_q) + res_q[IX_WTR];
    rd2wr_w  = CYC_W'(cl_q) + CYC_W'(BURST_LEN / 2 + 2) - CYC_W'(cwl_q);
    rasmax_w = RAS_W'(res_q[IX_REFI]) * RAS_W'(9);
    for (int k = 0; k < N_TMG; k++) res_flat[k*CYC_W +: CYC_W] = res_q[k];
    full_vec = {rd2wr_w, wr2rd_w, ckesr_w, res_flat};
    cl_inc   = {1'b0, cl_q} + 1'b1;
    cwl_inc  = {1'b0, cwl_q} + 1'b1;
  end

  ddr3_half_fields #(.M(M_HALF), .W(CYC_W)) u_half (
    .full(full_vec),
    .half(half_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      freq_q  <= '0;
      tck_q   <= '0;
      cl_q    <= '0;
      cwl_q   <= '0;
      for (int k = 0; k < N_TMG; k++) res_q[k] <= '0;
      cyc_o          <= '0;
      half_o         <= '0;
      cl_o           <= '0;
      cwl_o          <= '0;
      cl_half_o      <= '0;
      cwl_half_o     <= '0;
      ckesr_o        <= '0;
      wr2rd_o        <= '0;
      rd2wr_o        <= '0;
      rasmax_o       <= '0;
      refi_x32_o     <= '0;
      rasmax_x1024_o <= '0;
      done_o         <= 1'b0;
      err_o          <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          freq_q  <= freq_mhz_i;
          state_q <= ST_TCK;
        end
        ST_TCK: if (div_idle) begin
          tck_q   <= div_quo;
          state_q <= ST_BIN;
        end
        ST_BIN: if (lu_hit) begin
          cl_q    <= lu_cl;
          cwl_q   <= lu_cwl;
          idx_q   <= '0;
          state_q <= ST_CONV;
        end else begin
          err_o   <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_CONV: if (div_idle) begin
          res_q[idx_q] <= res_new;
          if (last_idx) state_q <= ST_FIN;
          else          idx_q   <= idx_q + 1'b1;
        end
        ST_FIN: begin
          cyc_o          <= res_flat;
          half_o         <= half_vec;
          cl_o           <= cl_q;
          cwl_o          <= cwl_q;
          cl_half_o      <= cl_inc[CL_W:1];
          cwl_half_o     <= cwl_inc[CL_W:1];
          ckesr_o        <= ckesr_w;
          wr2rd_o        <= wr2rd_w;
          rd2wr_o        <= rd2wr_w;
          rasmax_o       <= rasmax_w;
          refi_x32_o     <= res_q[IX_REFI][CYC_W-1:5];
          rasmax_x1024_o <= rasmax_w[RAS_W-1:10];
          done_o         <= 1'b1;
          state_q        <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_done_err_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(cyc_o) && $stable(rasmax_o)));

  p_err_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ($stable(cyc_o) && $stable(cl_o) && $stable(cwl_o)));

  p_load_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    div_load |-> div_idle);

endmodule

// File: tb/sim_ddr3_tmg_conv.sv
module sim_ddr3_tmg_conv;
  localparam int NT = 13;
  localparam int NB = 5;
  localparam int DW = 20;
  localparam int CW = 16;
  localparam int LW = 5;
  localparam int TW = 16;
  localparam int DIVW = 33;
  localparam int DONE_LAT = DIVW + 3 + (DIVW + 1) * NT;
  localparam int ERR_LAT  = DIVW + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [11:0] freq = '0;
  logic [NT*DW-1:0] dur = '0;
  logic [NT*CW-1:0] ckmin = '0;
  logic [NB*LW-1:0] tcl = '0, tcwl = '0;
  logic [NB*TW-1:0] tmin = '0, tmax = '0;

  logic [NT*CW-1:0] cyc_o;
  logic [(NT+3)*CW-1:0] half_o;
  logic [LW-1:0] cl_o, cwl_o, cl_half_o, cwl_half_o;
  logic [CW-1:0] ckesr_o, wr2rd_o, rd2wr_o;
  logic [CW+3:0] rasmax_o;
  logic [CW-6:0] refi_x32_o;
  logic [CW-7:0] rasmax_x1024_o;
  logic done_o, err_o;

  always #2.5 clk = ~clk;

  ddr3_tmg_conv u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .freq_mhz_i(freq),
    .dur_i(dur), .ckmin_i(ckmin), .bin_cl_i(tcl), .bin_cwl_i(tcwl),
    .bin_tckmin_i(tmin), .bin_tckmax_i(tmax),
    .cyc_o(cyc_o), .half_o(half_o), .cl_o(cl_o), .cwl_o(cwl_o),
    .cl_half_o(cl_half_o), .cwl_half_o(cwl_half_o), .ckesr_o(ckesr_o),
    .wr2rd_o(wr2rd_o), .rd2wr_o(rd2wr_o), .rasmax_o(rasmax_o),
    .refi_x32_o(refi_x32_o), .rasmax_x1024_o(rasmax_x1024_o),
    .done_o(done_o), .err_o(err_o)
  );

  int n_chk = 0, n_err = 0, cycles = 0, done_seen = 0;
  bit cmp_on = 0;

  // behavioural model state
  longint e_cyc[NT], p_cyc[NT];
  longint e_cl, e_cwl, p_cl, p_cwl;
  bit e_done, e_err, m_busy, m_fail;
  int m_cnt;

  task automatic chk(longint act, longint exp, string tag, string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic longint convert(int k, longint d, longint f, longint floor_ck);
    longint den, x, q;
    den = (k <= 2) ? 1000 : 1000000;
    x = d * f;
    q = x / den;
    if (!(k == 0 || k == 2) && (x % den) != 0) q = q + 1;
    if (q > 65535) q = 65535;
    if (q < floor_ck) q = floor_ck;
    return q;
  endfunction

  always @(posedge clk) begin
    e_done = 0;
    e_err  = 0;
    if (!rst_n) begin
      m_busy = 0;
      m_cnt = 0;
      e_cl = 0; e_cwl = 0;
      for (int k = 0; k < NT; k++) e_cyc[k] = 0;
    end else if (m_busy) begin
      m_cnt++;
      if (m_fail && m_cnt == ERR_LAT) begin
        e_err = 1; m_busy = 0;
      end else if (!m_fail && m_cnt == DONE_LAT) begin
        e_done = 1; m_busy = 0;
        e_cl = p_cl; e_cwl = p_cwl;
        for (int k = 0; k < NT; k++) e_cyc[k] = p_cyc[k];
      end
    end else if (start) begin
      longint tck;
      m_busy = 1; m_cnt = 0; m_fail = 1;
      tck = (freq == 0) ? 64'h7fffffff : 1000000 / longint'(freq);
      for (int b = 0; b < NB && m_fail; b++) begin
        if (tmin[b*TW +: TW] <= tck && tck < tmax[b*TW +: TW]) begin
          m_fail = 0;
          p_cl = tcl[b*LW +: LW];
          p_cwl = tcwl[b*LW +: LW];
        end
      end
      for (int k = 0; k < NT; k++)
        p_cyc[k] = convert(k, dur[k*DW +: DW], freq, ckmin[k*CW +: CW]);
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      longint ck, wr, rd, rm;
      chk(done_o, e_done, "R9", "done");
      chk(err_o, e_err, "R3", "err");
      chk(done_o && err_o, 0, "R11", "done and err together");
      if (done_o) done_seen++;
      for (int k = 0; k < NT; k++) begin
        chk(cyc_o[k*CW +: CW], e_cyc[k],
            (k == 0 || k == 2) ? "R5" : ((k >= 7) ? "R6" : "R4"), $sformatf("count[%0d]", k));
        chk(half_o[k*CW +: CW], (e_cyc[k] + 1) / 2, "R8", $sformatf("half[%0d]", k));
      end
      ck = e_cyc[12] + 1;
      wr = (4 + e_cwl + e_cyc[8]) & 16'hffff;
      rd = (e_cl + 6 - e_cwl) & 16'hffff;
      rm = 9 * e_cyc[0];
      if (e_cl == 0) begin ck = 0; wr = 0; rd = 0; rm = 0; end
      chk(cl_o, e_cl, "R2", "cl");
      chk(cwl_o, e_cwl, "R2", "cwl");
      chk(ckesr_o, ck, "R7", "ckesr");
      chk(wr2rd_o, wr, "R7", "wr2rd");
      chk(rd2wr_o, rd, "R7", "rd2wr");
      chk(rasmax_o, rm, "R7", "rasmax");
      chk(half_o[13*CW +: CW], (ck + 1) / 2, "R8", "half ckesr");
      chk(half_o[14*CW +: CW], (wr + 1) / 2, "R8", "half wr2rd");
      chk(half_o[15*CW +: CW], (rd + 1) / 2, "R8", "half rd2wr");
      chk(cl_half_o, (e_cl + 1) / 2, "R8", "cl half");
      chk(cwl_half_o, (e_cwl + 1) / 2, "R8", "cwl half");
      chk(refi_x32_o, e_cyc[0] / 32, "R8", "refi/32");
      chk(rasmax_x1024_o, rm / 1024, "R8", "rasmax/1024");
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic set_tmg(int k, int d, int c);
    dur[k*DW +: DW] = DW'(d);
    ckmin[k*CW +: CW] = CW'(c);
  endtask

  task automatic set_bin(int b, int c, int w, int lo, int hi);
    tcl[b*LW +: LW] = LW'(c);
    tcwl[b*LW +: LW] = LW'(w);
    tmin[b*TW +: TW] = TW'(lo);
    tmax[b*TW +: TW] = TW'(hi);
  endtask

  // run one conversion; optionally fire a second start mid-run (R10)
  task automatic run(int f, int intrude_f);
    int d0;
    @(negedge clk);
    freq = 12'(f);
    start = 1;
    @(negedge clk);
    start = 0;
    d0 = done_seen;
    if (intrude_f > 0) begin
      repeat (100) @(negedge clk);
      freq = 12'(intrude_f);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
    if (intrude_f > 0) chk(done_seen - d0, 1, "R10", "done pulses with mid-run start");
  endtask

  initial begin
    set_bin(0, 5, 5, 3000, 3300);
    set_bin(1, 6, 5, 2500, 3300);
    set_bin(2, 8, 6, 1875, 2500);
    set_bin(3, 10, 7, 1500, 1875);
    set_bin(4, 11, 8, 1250, 1500);
    set_tmg(0, 7800, 0);  set_tmg(1, 260, 0);   set_tmg(2, 15, 0);
    set_tmg(3, 13750, 0); set_tmg(4, 13750, 0); set_tmg(5, 48750, 0);
    set_tmg(6, 35000, 0); set_tmg(7, 7500, 4);  set_tmg(8, 7500, 4);
    set_tmg(9, 15000, 12); set_tmg(10, 7500, 4); set_tmg(11, 6000, 3);
    set_tmg(12, 5625, 3);
    repeat (4) @(negedge clk);
    cmp_on = 1;
    chk(done_o, 0, "R1", "done in reset");
    chk(cyc_o, 0, "R1", "counts in reset");
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(rasmax_o, 0, "R1", "rasmax after reset");
    chk(err_o, 0, "R1", "err after reset");
    run(400, 0);
    chk(cl_o, 6, "R2", "cl at 400 MHz");
    run(533, 667);
    chk(cl_o, 8, "R10", "cl kept from accepted start");
    run(667, 0);
    run(800, 0);
    chk(cyc_o[0 +: CW], 6240, "R5", "refresh interval at 800 MHz");
    run(300, 0);
    chk(cl_o, 11, "R3", "cl unchanged after error");
    run(310, 0);
    chk(cl_o, 5, "R2", "lowest index wins");
    set_tmg(0, 1048575, 0);
    run(800, 0);
    chk(cyc_o[0 +: CW], 65535, "R6", "saturated refresh interval");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule